// File: doc/BRIEF.md
# Address Generation and Next-PC Select

This block forms memory addresses and the next program-counter value for a 16-bit processor datapath. A single address adder adds a sign-extended offset field from the instruction word to one chosen base: zero, the current program counter, or a value read from a base register. That one sum serves base-plus-offset loads and stores, PC-relative branches and jumps.

The program counter lives inside the block. When the sequencer asserts the load enable, the counter takes one of three values: its own value plus one, the adder sum, or the shared bus value used on trap entry. A second selector picks the value offered to the memory address register: either the adder sum or the low eight bits of the instruction, zero-extended, which gives a trap vector address. The adder result and the address candidate are registered every cycle. The register file, the memory and the control sequencer are outside this block.

Top module: `agu_pcsel`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` becomes `RESET_PC` (default 16'h3000) and `addr_q` and `mar_q` become zero.
- R2: `off_sel` picks the offset field and sign-extends it to 16 bits: 0 takes `ir[5:0]`, 1 takes `ir[8:0]`, 2 takes `ir[10:0]`, and 3 gives an offset of zero.
- R3: `base_sel` picks the adder base: 0 gives zero, 1 gives the current `pc_q`, 2 gives `base_val`, and 3 gives zero.
- R4: The adder sum wraps modulo 2^16. No carry or overflow is reported.
- R5: `addr_q` takes the sum (base + offset) of the inputs present at each clock edge. The value appears one cycle later.
- R6: When `pc_ld` is low, `pc_q` keeps its value, whatever the other inputs are.
- R7: When `pc_ld` is high, `pc_sel` picks the next `pc_q`: 0 gives `pc_q`+1 (wrapping), 1 gives the adder sum, 2 gives `bus_val`, and 3 gives `pc_q`+1.
- R8: `mar_q` is loaded at every edge. `mar_sel` 1 gives `{8'h00, ir[7:0]}`, and `mar_sel` 0, 2 and 3 give the adder sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 16 | Instruction word |
| base_val | input | 16 | Base register value |
| bus_val | input | 16 | Shared bus value (trap target) |
| base_sel | input | 2 | Adder base select |
| off_sel | input | 2 | Offset field width select |
| pc_sel | input | 2 | Next-PC source select |
| mar_sel | input | 2 | Address-register candidate select |
| pc_ld | input | 1 | Program counter load enable |
| pc_q | output | 16 | Program counter |
| mar_q | output | 16 | Registered address-register candidate |
| addr_q | output | 16 | Registered adder result |

## Verification
The assertions assume that every select input holds a defined two-bit value at each sampled edge. They also assume that the selects sampled by the adder and by the PC and address multiplexers in one cycle are the same ones, so a sum captured in `addr_q` can be compared with the value loaded into `pc_q` or `mar_q` in the same cycle. The stimulus changes every input only just after a rising edge, and it never leaves a select undriven. Reserved codes are driven on purpose, so their fallback choices are checked as well.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {BASE_ZERO = 2'd0, BASE_PC = 2'd1, BASE_REG = 2'd2, BASE_RSV = 2'd3} base_sel_e;
  typedef enum logic [1:0] {OFF_NARROW = 2'd0, OFF_MID = 2'd1, OFF_WIDE = 2'd2, OFF_NONE = 2'd3} off_sel_e;
  typedef enum logic [1:0] {NPC_INC = 2'd0, NPC_ADDER = 2'd1, NPC_BUS = 2'd2, NPC_RSV = 2'd3} pc_sel_e;
  typedef enum logic [1:0] {MAR_ADDER = 2'd0, MAR_VECTOR = 2'd1, MAR_RSV2 = 2'd2, MAR_RSV3 = 2'd3} mar_sel_e;
endpackage

// File: rtl/agu_sext.sv
module agu_sext #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;
  assign dout = {{PAD_W{din[IN_W-1]}}, din};
endmodule

// File: rtl/agu_addr_path.sv
module agu_addr_path
  import agu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int OFF_A = 6,
  parameter int OFF_B = 9,
  parameter int OFF_C = 11
) (
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] base_val,
  input  logic [1:0]    base_sel,
  input  logic [1:0]    off_sel,
  output logic [DW-1:0] sum
);
  localparam int NOFF = 3;
  localparam int OFFW [NOFF] = '{OFF_A, OFF_B, OFF_C};

  logic [DW-1:0] ext [NOFF];
  logic [DW-1:0] offset;
  logic [DW-1:0] base;

  for (genvar g = 0; g < NOFF; g++) begin : g_ext
    agu_sext #(.IN_W(OFFW[g]), .OUT_W(DW)) u_sext (
      .din  (ir[OFFW[g]-1:0]),
      .dout (ext[g])
    );
  end

  always_comb begin
    unique case (off_sel_e'(off_sel))
      OFF_NARROW: offset = ext[0];
      OFF_MID:    offset = ext[1];
      OFF_WIDE:   offset = ext[2];
      default:    offset = '0;
    endcase
  end

  always_comb begin
    unique case (base_sel_e'(base_sel))
      BASE_PC:  base = pc;
      BASE_REG: base = base_val;
      default:  base = '0;
    endcase
  end

  assign sum = base + offset;
endmodule

// File: rtl/agu_target_mux.sv
module agu_target_mux
  import agu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int VEC_W = 8
) (
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] sum,
  input  logic [DW-1:0] bus_val,
  input  logic [DW-1:0] ir,
  input  logic [1:0]    pc_sel,
  input  logic [1:0]    mar_sel,
  output logic [DW-1:0] pc_next,
  output logic [DW-1:0] mar_next
);
  localparam int ZPAD = DW - VEC_W;
  logic [DW-1:0] pc_inc;
  logic [DW-1:0] vec_addr;

  assign pc_inc   = pc + DW'(1);
  assign vec_addr = {{ZPAD{1'b0}}, ir[VEC_W-1:0]};

  always_comb begin
    unique case (pc_sel_e'(pc_sel))
      NPC_ADDER: pc_next = sum;
      NPC_BUS:   pc_next = bus_val;
      default:   pc_next = pc_inc;
    endcase
  end

  always_comb begin
    unique case (mar_sel_e'(mar_sel))
      MAR_VECTOR: mar_next = vec_addr;
      default:    mar_next = sum;
    endcase
  end
endmodule

// File: rtl/agu_pcsel.sv
module agu_pcsel
  import agu_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          OFF_A    = 6,
  parameter int          OFF_B    = 9,
  parameter int          OFF_C    = 11,
  parameter int          VEC_W    = 8,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] bus_val,
  input  logic [1:0]    base_sel,
  input  logic [1:0]    off_sel,
  input  logic [1:0]    pc_sel,
  input  logic [1:0]    mar_sel,
  input  logic          pc_ld,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] addr_q
);
  localparam logic [DW-1:0] PC_INIT = DW'(RESET_PC);

  logic [DW-1:0] sum;
  logic [DW-1:0] pc_next;
  logic [DW-1:0] mar_next;

  agu_addr_path #(.DW(DW), .OFF_A(OFF_A), .OFF_B(OFF_B), .OFF_C(OFF_C)) u_addr (
    .ir       (ir),
    .pc       (pc_q),
    .base_val (base_val),
    .base_sel (base_sel),
    .off_sel  (off_sel),
    .sum      (sum)
  );

  agu_target_mux #(.DW(DW), .VEC_W(VEC_W)) u_mux (
    .pc       (pc_q),
    .sum      (sum),
    .bus_val  (bus_val),
    .ir       (ir),
    .pc_sel   (pc_sel),
    .mar_sel  (mar_sel),
    .pc_next  (pc_next),
    .mar_next (mar_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= PC_INIT;
      mar_q  <= '0;
      addr_q <= '0;
    end else begin
      if (pc_ld) pc_q <= pc_next;
      mar_q  <= mar_next;
      addr_q <= sum;
    end
  end

  // R1: reset values
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_q == PC_INIT && mar_q == '0 && addr_q == '0));

  // R6: PC holds without load
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_ld |=> $stable(pc_q));

  // R7: increment path
  a_r7_pc_inc: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && (pc_sel == 2'd0 || pc_sel == 2'd3)) |=> pc_q == $past(pc_q) + DW'(1));

  // R7: adder path agrees with captured sum
  a_r7_pc_adder: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && pc_sel == 2'd1) |=> pc_q == addr_q);

  // R7: bus path
  a_r7_pc_bus: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && pc_sel == 2'd2) |=> pc_q == $past(bus_val));

  // R8: vector path zero-extends
  a_r8_mar_vector: assert property (@(posedge clk) disable iff (rst)
    (mar_sel == 2'd1) |=> mar_q == {{(DW-VEC_W){1'b0}}, $past(ir[VEC_W-1:0])});

  // R8: other codes follow the adder
  a_r8_mar_adder: assert property (@(posedge clk) disable iff (rst)
    (mar_sel != 2'd1) |=> mar_q == addr_q);
endmodule

// File: tb/sim_agu_pcsel.sv
module sim_agu_pcsel;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] ir = '0, base_val = '0, bus_val = '0;
  logic [1:0]    base_sel = '0, off_sel = '0, pc_sel = '0, mar_sel = '0;
  logic          pc_ld = 1'b0;
  logic [DW-1:0] pc_q, mar_q, addr_q;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  agu_pcsel u0 (
    .clk(clk), .rst(rst), .ir(ir), .base_val(base_val), .bus_val(bus_val),
    .base_sel(base_sel), .off_sel(off_sel), .pc_sel(pc_sel), .mar_sel(mar_sel),
    .pc_ld(pc_ld), .pc_q(pc_q), .mar_q(mar_q), .addr_q(addr_q)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] offs(input logic [DW-1:0] w, input logic [1:0] s);
    case (s)
      2'd0: return {{10{w[5]}}, w[5:0]};
      2'd1: return {{7{w[8]}}, w[8:0]};
      2'd2: return {{5{w[10]}}, w[10:0]};
      default: return '0;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    chk("R1 pc", pc_q, 16'h3000);
    chk("R1 mar", mar_q, 16'h0000);
    chk("R1 addr", addr_q, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_offsets();
    pc_ld = 0; mar_sel = 2'd0; base_sel = 2'd0;
    ir = 16'h0420;
    for (int s = 0; s < 4; s++) begin
      off_sel = 2'(s);
      step();
      chk("R2 offset width", addr_q, offs(ir, 2'(s)));
    end
    ir = 16'h0315; off_sel = 2'd2;
    step();
    chk("R2 positive wide", addr_q, 16'h0315);
    ir = 16'h0130; off_sel = 2'd1;
    step();
    chk("R2 negative mid", addr_q, 16'hFF30);
  endtask

  task automatic t_bases();
    logic [DW-1:0] pc0;
    pc_ld = 0; pc0 = pc_q;
    base_val = 16'h1234; ir = 16'h0005; off_sel = 2'd0;
    base_sel = 2'd0; step(); chk("R3 zero base", addr_q, 16'h0005);
    base_sel = 2'd1; step(); chk("R3 pc base", addr_q, pc0 + 16'h0005);
    base_sel = 2'd2; step(); chk("R3 reg base", addr_q, 16'h1239);
    base_sel = 2'd3; step(); chk("R3 reserved base", addr_q, 16'h0005);
    chk("R5 mar follows sum", mar_q, 16'h0005);
  endtask

  task automatic t_wrap();
    pc_ld = 0; base_sel = 2'd2; base_val = 16'hFFFF; ir = 16'h0001; off_sel = 2'd0;
    step(); chk("R4 wrap up", addr_q, 16'h0000);
    base_val = 16'h0002; ir = 16'h003C;
    step(); chk("R4 wrap down", addr_q, 16'hFFFE);
  endtask

  task automatic t_pc_hold();
    logic [DW-1:0] pc0;
    pc0 = pc_q; pc_ld = 0; pc_sel = 2'd2; bus_val = 16'hBEEF;
    step(); step();
    chk("R6 hold", pc_q, pc0);
  endtask

  task automatic t_pc_sel();
    logic [DW-1:0] p;
    pc_ld = 1;
    p = pc_q; pc_sel = 2'd0; step(); chk("R7 inc", pc_q, p + 16'd1);
    p = pc_q; pc_sel = 2'd3; step(); chk("R7 reserved inc", pc_q, p + 16'd1);
    bus_val = 16'h00A5; pc_sel = 2'd2; step(); chk("R7 bus", pc_q, 16'h00A5);
    p = pc_q; base_sel = 2'd1; off_sel = 2'd1; ir = 16'h01FE; pc_sel = 2'd1;
    step(); chk("R7 adder branch", pc_q, p + 16'hFFFE);
    bus_val = 16'hFFFF; pc_sel = 2'd2; step();
    pc_sel = 2'd0; step(); chk("R7 inc wrap", pc_q, 16'h0000);
    pc_ld = 0;
  endtask

  task automatic t_mar();
    base_sel = 2'd2; base_val = 16'h4000; off_sel = 2'd0; ir = 16'hF38B;
    mar_sel = 2'd1; step(); chk("R8 vector", mar_q, 16'h008B);
    mar_sel = 2'd0; step(); chk("R8 adder", mar_q, 16'h4000 + offs(16'hF38B, 2'd0));
    mar_sel = 2'd2; step(); chk("R8 reserved 2", mar_q, 16'h4000 + offs(16'hF38B, 2'd0));
    mar_sel = 2'd3; ir = 16'h0011; step(); chk("R8 reserved 3", mar_q, 16'h4011);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_offsets();
    t_bases();
    t_wrap();
    t_pc_hold();
    t_pc_sel();
    t_mar();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule